// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Each line passes through a two-flop synchroniser. It is then treated as edge-sensitive (a rising edge latches a request) or level-sensitive (the request is re-latched for as long as the line is held high). A per-line build-time kind mask selects between the two. Latched requests live in a status register. A separate enable register masks them, and the masked result is the pending set. The processor output rises when anything is pending and the output-enable bit of the master register is set.

Software reaches the block through a plain 32-bit register port with a 3-bit word index; a byte offset is four times the index. Reads are combinational from the index, and a write takes effect on the next rising clock edge. Word 0 is status, word 1 pending, word 2 enable, word 3 acknowledge, word 4 set-enable, word 5 clear-enable, word 6 vector and word 7 master. In the master register, bit 0 gates the interrupt output and bit 1 allows the input lines to update status. The vector word returns the index of the lowest-numbered pending line, so the lowest index has the highest priority. A handler reads the vector, services that line, writes its bit to the acknowledge word, and reads the vector again until it returns all ones.

Top module: `irqc_top`

## Requirements
- R1: After reset, status, enable and master read 0, pending reads 0, `irq_out` is low and the vector reads 0xFFFFFFFF.
- R2: Enable (word 2) and master bits [1:0] (word 7) read back what was written. Words 3, 4 and 5 are write-only and read as 0.
- R3: Writing to word 3 clears every status bit written as 1 and leaves status bits written as 0 unchanged. Writing 0xFFFFFFFF clears all of status.
- R4: Writing to word 4 sets the enable bits written as 1, and writing to word 5 clears them. Zero bits leave enable unchanged. A direct write of 0 to word 2 disables every line.
- R5: Pending (word 1) reads as status AND enable.
- R6: `irq_out` is high exactly when pending is nonzero and master bit 0 is 1.
- R7: The vector (word 6) returns the lowest index whose pending bit is 1, zero-extended to 32 bits. It returns 0xFFFFFFFF when pending is 0.
- R8: A line whose kind-mask bit is 1 latches its status bit once per rising edge. Holding it high does not set the bit again after an acknowledge.
- R9: A line whose kind-mask bit is 0 and that is still high sets its status bit again in the same edge that an acknowledge would have cleared it, so status stays 1.
- R10: A change driven on a line just before rising clock edge k appears in status after edge k+2, and not after edge k+1.
- R11: While master bit 1 is 0, the lines do not change status. A rising edge on an edge-kind line seen only during that time is lost.
- R12: Status, enable and pending bits at or above the line count `NUM_IN` read as 0, and kind-mask bits at or above `NUM_IN` are ignored.
- R13: Writes to words 0, 1 and 6 change neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_IN | Asynchronous interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_word` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench drives a level line that is still held high while it is acknowledged; a design that lets the clear win would drop a request that is still active. It holds an edge-kind line high across an acknowledge, which catches a design that treats held edges as levels. It also pulses an edge line while input updates are disabled, which catches a design that remembers the edge and fires when updates are turned back on. Further checks cover: two lines pending at once with different enable patterns, which exposes a priority encoder that favours the highest index or ignores the enable mask; the exact latency edge of the synchroniser; and writes to read-only words, which a loose address decode would let through.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        RW_STATUS = 3'd0,
        RW_PEND   = 3'd1,
        RW_ENABLE = 3'd2,
        RW_ACK    = 3'd3,
        RW_SETEN  = 3'd4,
        RW_CLREN  = 3'd5,
        RW_VECTOR = 3'd6,
        RW_MASTER = 3'd7
    } reg_word_e;

    // Bit 1: inputs may update status; bit 0: output gate.
    typedef struct packed {
        logic hw_en;
        logic out_en;
    } master_t;

    typedef struct packed {
        logic                    wr;
        reg_word_e               sel;
        logic [WORD_W-1:0]       data;
    } bus_wr_t;

    localparam logic [WORD_W-1:0] VEC_NONE = '1;

    function automatic reg_word_e word_decode(input logic [2:0] idx);
        return reg_word_e'(idx);
    endfunction

endpackage

// File: rtl/irqc_in_cond.sv
module irqc_in_cond #(
    parameter int unsigned NUM_IN    = 32,
    parameter logic [31:0] KIND_MASK = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] lines,
    output logic [NUM_IN-1:0] hit
);
    logic [NUM_IN-1:0] sync_a;
    logic [NUM_IN-1:0] sync_b;
    logic [NUM_IN-1:0] prev_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= '0;
            sync_b <= '0;
            prev_b <= '0;
        end else begin
            sync_a <= lines;
            sync_b <= sync_a;
            prev_b <= sync_b;
        end
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
        if (KIND_MASK[i]) begin : g_edge
            assign hit[i] = sync_b[i] & ~prev_b[i];
        end else begin : g_level
            assign hit[i] = sync_b[i];
        end

        // A request seen by the register stage was on the pin two edges earlier.
        p_hit_latency_r10: assert property (@(posedge clk) disable iff (rst)
            hit[i] |-> $past(lines[i], 2));
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned NUM_IN = 32,
    localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0] req,
    output logic              valid,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           bus,
    input  logic [NUM_IN-1:0] hit,
    output logic [NUM_IN-1:0] status,
    output logic [NUM_IN-1:0] enable,
    output master_t           master
);
    logic [NUM_IN-1:0] wbits;
    logic [NUM_IN-1:0] hw_set;
    logic [NUM_IN-1:0] ack_clr;
    logic              ack_wr;

    assign wbits   = bus.data[NUM_IN-1:0];
    assign ack_wr  = bus.wr && (bus.sel == RW_ACK);
    assign hw_set  = master.hw_en ? hit : '0;
    assign ack_clr = ack_wr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            // A line still requesting wins over an acknowledge in the same edge.
            status <= (status & ~ack_clr) | hw_set;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            master <= '0;
        end else if (bus.wr) begin
            case (bus.sel)
                RW_ENABLE: enable <= wbits;
                RW_SETEN:  enable <= enable | wbits;
                RW_CLREN:  enable <= enable & ~wbits;
                RW_MASTER: master <= master_t'(bus.data[1:0]);
                default:   ;
            endcase
        end
    end

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> ((status & $past(wbits) & ~$past(hw_set)) == '0));

    p_seten_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (bus.wr && bus.sel == RW_SETEN) |=> ((enable & $past(wbits)) == $past(wbits)));

    p_clren_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (bus.wr && bus.sel == RW_CLREN) |=> ((enable & $past(wbits)) == '0));

    p_hw_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!master.hw_en && !ack_wr) |=> $stable(status));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IN    = 32,
    parameter logic [31:0] KIND_MASK = 32'h0000_0000,
    localparam int unsigned IDX_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_lines,
    input  logic              bus_wr,
    input  logic [2:0]        bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);
    bus_wr_t           bus;
    logic [NUM_IN-1:0] hit;
    logic [NUM_IN-1:0] status;
    logic [NUM_IN-1:0] enable;
    logic [NUM_IN-1:0] pending;
    master_t           master;
    logic              vec_valid;
    logic [IDX_W-1:0]  vec_idx;
    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] enable_w;
    logic [WORD_W-1:0] pending_w;
    logic [WORD_W-1:0] vector_w;
    logic [NUM_IN-1:0] below_mask;

    assign bus.wr   = bus_wr;
    assign bus.sel  = word_decode(bus_word);
    assign bus.data = bus_wdata;

    irqc_in_cond #(
        .NUM_IN   (NUM_IN),
        .KIND_MASK(KIND_MASK)
    ) u_in_cond (
        .clk  (clk),
        .rst  (rst),
        .lines(irq_lines),
        .hit  (hit)
    );

    irqc_regs #(
        .NUM_IN(NUM_IN)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .bus   (bus),
        .hit   (hit),
        .status(status),
        .enable(enable),
        .master(master)
    );

    assign pending = status & enable;

    irqc_prio #(
        .NUM_IN(NUM_IN)
    ) u_prio (
        .req  (pending),
        .valid(vec_valid),
        .idx  (vec_idx)
    );

    assign irq_out = master.out_en && (pending != '0);

    always_comb begin
        status_w  = '0;
        enable_w  = '0;
        pending_w = '0;
        status_w[NUM_IN-1:0]  = status;
        enable_w[NUM_IN-1:0]  = enable;
        pending_w[NUM_IN-1:0] = pending;
        vector_w = vec_valid ? WORD_W'(vec_idx) : VEC_NONE;
    end

    always_comb begin
        case (bus.sel)
            RW_STATUS: bus_rdata = status_w;
            RW_PEND:   bus_rdata = pending_w;
            RW_ENABLE: bus_rdata = enable_w;
            RW_VECTOR: bus_rdata = vector_w;
            RW_MASTER: bus_rdata = {30'd0, master};
            default:   bus_rdata = '0;
        endcase
    end

    always_comb begin
        below_mask = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            below_mask[i] = (IDX_W'(i) < vec_idx);
        end
    end

    p_vec_is_pending_r7: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> pending[vec_idx]);

    p_vec_lowest_r7: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> ((pending & below_mask) == '0));

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (master.out_en && vec_valid));

    p_irq_raised_r6: assert property (@(posedge clk) disable iff (rst)
        (master.out_en && vec_valid) |-> irq_out);

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    localparam int unsigned NUM_IN    = 16;
    localparam logic [31:0] KIND_MASK = 32'hABCD_00F0; // lines 4..7 edge, others level

    localparam logic [2:0] W_STAT = 3'd0, W_PEND = 3'd1, W_EN = 3'd2, W_ACK = 3'd3,
                           W_SET = 3'd4, W_CLR = 3'd5, W_VEC = 3'd6, W_MST = 3'd7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_IN-1:0] irq_lines = '0;
    logic              bus_wr = 1'b0;
    logic [2:0]        bus_word = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irqc_top #(
        .NUM_IN   (NUM_IN),
        .KIND_MASK(KIND_MASK)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .irq_lines(irq_lines),
        .bus_wr   (bus_wr),
        .bus_word (bus_word),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_out  (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int i);
        @(negedge clk); irq_lines[i] = 1'b1;
        idle(3);
        irq_lines[i] = 1'b0;
        idle(3);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(W_STAT, v); check("R1 status", v, 0);
        rd(W_PEND, v); check("R1 pending", v, 0);
        rd(W_EN, v);   check("R1 enable", v, 0);
        rd(W_MST, v);  check("R1 master", v, 0);
        rd(W_VEC, v);  check("R1 vector", v, 32'hFFFF_FFFF);
        check("R1 irq_out", {31'd0, irq_out}, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(W_EN, 32'h0000_A00F); rd(W_EN, v); check("R2 enable readback", v, 32'h0000_A00F);
        wr(W_EN, 32'hFFFF_FFFF); rd(W_EN, v); check("R12 enable upper bits", v, 32'h0000_FFFF);
        wr(W_MST, 32'hFFFF_FFFE); rd(W_MST, v); check("R2 master readback", v, 32'h2);
        rd(W_ACK, v); check("R2 ack reads 0", v, 0);
        rd(W_SET, v); check("R2 seten reads 0", v, 0);
        rd(W_CLR, v); check("R2 clren reads 0", v, 0);
        wr(W_STAT, 32'hFFFF_FFFF); rd(W_STAT, v); check("R13 status write ignored", v, 0);
        wr(W_PEND, 32'h0); wr(W_VEC, 32'h0);
        rd(W_EN, v); check("R13 enable after ro writes", v, 32'h0000_FFFF);
        wr(W_EN, 32'h0); rd(W_EN, v); check("R4 enable write 0", v, 0);
        wr(W_MST, 32'h0);
    endtask

    task automatic t_setclr;
        logic [31:0] v;
        wr(W_EN, 32'h00FF);
        wr(W_SET, 32'h0F00); rd(W_EN, v); check("R4 seten", v, 32'h0FFF);
        wr(W_CLR, 32'h00F0); rd(W_EN, v); check("R4 clren", v, 32'h0F0F);
        wr(W_SET, 32'h0);    rd(W_EN, v); check("R4 seten zero", v, 32'h0F0F);
        wr(W_CLR, 32'h0);    rd(W_EN, v); check("R4 clren zero", v, 32'h0F0F);
        wr(W_EN, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        wr(W_MST, 32'h3);
        wr(W_EN, 32'h0004);
        @(negedge clk); irq_lines[2] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        check("R10 not yet after edge k+1", {31'd0, dut_i.bus_rdata == bus_rdata && irq_out}, 0);
        @(negedge clk); #1;
        check("R10 irq after edge k+2", {31'd0, irq_out}, 1);
        rd(W_STAT, v); check("R10 status set", v, 32'h4);
        rd(W_VEC, v);  check("R7 vector line 2", v, 2);
        wr(W_ACK, 32'h4);
        rd(W_STAT, v); check("R9 level re-set after ack", v, 32'h4);
        irq_lines[2] = 1'b0;
        idle(4);
        wr(W_ACK, 32'h4);
        rd(W_STAT, v); check("R3 ack clears level", v, 0);
        rd(W_VEC, v);  check("R7 vector none", v, 32'hFFFF_FFFF);
        check("R6 irq low when none pending", {31'd0, irq_out}, 0);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(W_EN, 32'h0020);
        @(negedge clk); irq_lines[5] = 1'b1;
        idle(4);
        rd(W_STAT, v); check("R8 edge latched", v, 32'h20);
        wr(W_ACK, 32'h20);
        idle(4);
        rd(W_STAT, v); check("R8 held edge not re-set", v, 0);
        irq_lines[5] = 1'b0;
        idle(3);
        pulse(5);
        rd(W_STAT, v); check("R8 second edge latched", v, 32'h20);
        wr(W_ACK, 32'hFFFF_FFFF);
        wr(W_EN, 32'h0);
    endtask

    task automatic t_ack_pend;
        logic [31:0] v;
        pulse(4); pulse(6);
        rd(W_STAT, v); check("R8 two edges latched", v, 32'h50);
        wr(W_EN, 32'h40);
        rd(W_PEND, v); check("R5 pending masked", v, 32'h40);
        rd(W_VEC, v);  check("R7 vector line 6", v, 6);
        check("R6 irq with pending", {31'd0, irq_out}, 1);
        wr(W_SET, 32'h10);
        rd(W_VEC, v);  check("R7 lowest wins", v, 4);
        wr(W_EN, 32'h0);
        rd(W_PEND, v); check("R5 pending zero enable", v, 0);
        rd(W_VEC, v);  check("R7 none when disabled", v, 32'hFFFF_FFFF);
        check("R6 irq low disabled", {31'd0, irq_out}, 0);
        wr(W_EN, 32'h50);
        wr(W_MST, 32'h2);
        check("R6 irq low master off", {31'd0, irq_out}, 0);
        rd(W_VEC, v);  check("R7 vector with master off", v, 4);
        wr(W_MST, 32'h3);
        wr(W_ACK, 32'h10);
        rd(W_STAT, v); check("R3 partial ack", v, 32'h40);
        wr(W_ACK, 32'h0);
        rd(W_STAT, v); check("R3 ack zero no effect", v, 32'h40);
        wr(W_ACK, 32'hFFFF_FFFF);
        rd(W_STAT, v); check("R3 ack all", v, 0);
    endtask

    task automatic t_hw_gate;
        logic [31:0] v;
        wr(W_MST, 32'h1);
        @(negedge clk); irq_lines[7] = 1'b1; irq_lines[1] = 1'b1;
        idle(5);
        rd(W_STAT, v); check("R11 no update when hw off", v, 0);
        wr(W_MST, 32'h3);
        idle(4);
        rd(W_STAT, v); check("R11 level set, edge lost", v, 32'h2);
        irq_lines = '0;
        idle(4);
        wr(W_ACK, 32'hFFFF_FFFF);
        rd(W_STAT, v); check("R11 cleared", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_setclr();
        t_level();
        t_edge();
        t_ack_pend();
        t_hw_gate();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule